// File: doc/BRIEF.md
# Transceiver Reset Sequencing Controller

This block brings a serial transceiver out of reset in a safe order. It runs entirely from one free-running system clock. On the transmit side it watches a PLL lock indication and drives an analog reset, a digital reset and a ready flag. On the receive side it watches a calibration-busy flag and the CDR lock-to-data status of each channel, and drives the same three outputs per channel.

Every status input is asynchronous to the system clock. Each one is passed through a two-flop synchronizer and then a stability filter before the sequencers use it. A manual-mode input per direction stops a loss of lock from restarting that direction's sequence. A global reset input forces every reset output high at once. With `SYNC_RESET` set, the release of that reset is also aligned to the system clock. Receive channels can either run their own sequencers (`SEPARATE_RX = 1`) or share one sequencer (`SEPARATE_RX = 0`). In the shared case the lock inputs are ANDed, the busy inputs are ORed and the manual setting is taken from channel 0.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst` is high, every analog and digital reset output is high and every ready output is low. This takes effect without waiting for a clock edge and lasts for as long as `rst` is held.
- R2: A status input change that lasts fewer than `STABLE_CYC` consecutive synchronized cycles has no effect on any output.
- R3: In each sequencer the analog reset is released before the digital reset. The analog reset is also held for at least `ANA_HOLD` cycles.
- R4: The digital reset is released no sooner than `STABLE_CYC + REL_DLY` cycles after lock is applied, and no later than 4 cycles beyond that. Ready rises exactly one cycle after the digital reset falls, and ready is never high while the digital reset is high.
- R5: With TX manual low, a loss of PLL lock re-asserts the TX digital reset and clears TX ready, while the TX analog reset stays released. Once lock returns, the sequence completes again.
- R6: With TX manual high, a loss of PLL lock after release has no effect. The first release after reset still waits for PLL lock.
- R7: While a channel's calibration-busy input is high, that channel keeps its analog reset and digital reset high and its ready low.
- R8: With RX manual low on a channel, a loss of lock-to-data re-asserts that channel's digital reset and clears its ready. Once lock returns, the sequence completes again.
- R9: With RX manual high on a channel, a loss of lock-to-data after release has no effect on that channel.
- R10: With `SEPARATE_RX = 1`, each channel is sequenced from its own busy, lock and manual inputs, independently of the other channels.
- R11: With `SEPARATE_RX = 0`, every channel releases only when all lock inputs are high. All RX outputs are then identical across channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Global reset, active high, asynchronous |
| tx_pll_lock | input | 1 | TX PLL lock status |
| tx_manual | input | 1 | 1: TX ignores lock loss after release |
| rx_cal_busy | input | NUM_CH | Per-channel initial calibration in progress |
| rx_cdr_lock | input | NUM_CH | Per-channel CDR locked to data |
| rx_manual | input | NUM_CH | 1: channel ignores lock loss after release |
| tx_ana_rst | output | 1 | TX analog reset |
| tx_dig_rst | output | 1 | TX digital reset |
| tx_ready | output | 1 | TX ready |
| rx_ana_rst | output | NUM_CH | RX analog reset per channel |
| rx_dig_rst | output | NUM_CH | RX digital reset per channel |
| rx_ready | output | NUM_CH | RX ready per channel |

## Verification
A one-cycle glitch on PLL lock is applied while TX is ready. A filter that is too short, or missing, would drop ready. The digital release time is measured against a window derived from the filter length and the release delay. A sequencer that skipped the delay would release early, and one with a misplaced ready register would show ready in the same cycle as the release, or two cycles after it. Lock loss is applied in both modes on both directions. A design that mixed up the manual sense, or that pulled the analog reset back in on a loss, shows the wrong level on ready or on the analog output. Calibration busy is held on one channel only, and shared mode is given a partial lock, to catch a design that ORs the locks or couples the channels.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  typedef enum logic [1:0] {
    SQ_ANA  = 2'd0,
    SQ_LOCK = 2'd1,
    SQ_DLY  = 2'd2,
    SQ_RUN  = 2'd3
  } sq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/xrs_filt.sv
module xrs_filt #(
  parameter int STABLE_CYC = 4,
  parameter bit INIT       = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= {2{INIT}};
      q    <= INIT;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], d};
      if (sync[1] != q) begin
        if (cnt == CW'(STABLE_CYC - 1)) begin
          q   <= sync[1];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  AST_FILT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> ($past(sync[1]) == q)); // R2
endmodule

// File: rtl/xrs_seq.sv
module xrs_seq
  import xrs_pkg::*;
#(
  parameter int ANA_HOLD = 8,
  parameter int REL_DLY  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  input  logic lock_i,
  input  logic man_i,
  output logic ana_o,
  output logic dig_o,
  output logic rdy_o
);
  localparam int CMAX = imax(ANA_HOLD, REL_DLY);
  localparam int CW   = $clog2(CMAX + 1);

  sq_state_t     st, nxt;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    nxt   = st;
    cnt_n = '0;
    case (st)
      SQ_ANA: begin
        cnt_n = (cnt == CW'(ANA_HOLD - 1)) ? cnt : cnt + 1'b1;
        if (!gate_i && (cnt == CW'(ANA_HOLD - 1))) begin
          nxt   = SQ_LOCK;
          cnt_n = '0;
        end
      end
      SQ_LOCK: begin
        if (lock_i) nxt = SQ_DLY;
      end
      SQ_DLY: begin
        if (!lock_i) begin
          nxt = SQ_LOCK;
        end else if (cnt == CW'(REL_DLY - 1)) begin
          nxt = SQ_RUN;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      SQ_RUN: begin
        if (!lock_i && !man_i) nxt = SQ_LOCK;
      end
      default: nxt = SQ_ANA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_ANA;
      cnt   <= '0;
      ana_o <= 1'b1;
      dig_o <= 1'b1;
      rdy_o <= 1'b0;
    end else begin
      st    <= nxt;
      cnt   <= cnt_n;
      ana_o <= (nxt == SQ_ANA);
      dig_o <= (nxt != SQ_RUN);
      rdy_o <= (nxt == SQ_RUN) && !dig_o;
    end
  end

  AST_RST_STATE: assert property (@(posedge clk)
    $past(rst) |-> (ana_o && dig_o && !rdy_o)); // R1
  AST_ANA_FIRST: assert property (@(posedge clk) disable iff (rst)
    !dig_o |-> !ana_o); // R3
  AST_RDY_NOT_DIG: assert property (@(posedge clk) disable iff (rst)
    rdy_o |-> !dig_o); // R4
  AST_RDY_ONE_CYC: assert property (@(posedge clk) disable iff (rst)
    $fell(dig_o) |=> (rdy_o || dig_o)); // R4
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_ANA && gate_i) |=> ana_o); // R7
  AST_MAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dig_o && man_i) |=> !dig_o); // R6 R9
  AST_AUTO_DROP: assert property (@(posedge clk) disable iff (rst)
    (!dig_o && !man_i && !lock_i) |=> (dig_o && !rdy_o)); // R5 R8
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int NUM_CH      = 2,
  parameter bit SEPARATE_RX = 1'b1,
  parameter int STABLE_CYC  = 4,
  parameter int ANA_HOLD    = 8,
  parameter int REL_DLY     = 16,
  parameter bit SYNC_RESET  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_pll_lock,
  input  logic              tx_manual,
  input  logic [NUM_CH-1:0] rx_cal_busy,
  input  logic [NUM_CH-1:0] rx_cdr_lock,
  input  logic [NUM_CH-1:0] rx_manual,
  output logic              tx_ana_rst,
  output logic              tx_dig_rst,
  output logic              tx_ready,
  output logic [NUM_CH-1:0] rx_ana_rst,
  output logic [NUM_CH-1:0] rx_dig_rst,
  output logic [NUM_CH-1:0] rx_ready
);
  logic rst_i;

  generate
    if (SYNC_RESET) begin : g_rsync
      logic [1:0] hold;
      always_ff @(posedge clk) begin
        if (rst) hold <= 2'b11;
        else     hold <= {hold[0], 1'b0};
      end
      assign rst_i = rst | hold[1];
    end else begin : g_rraw
      assign rst_i = rst;
    end
  endgenerate

  logic tx_lock_f, tx_man_f;
  logic [NUM_CH-1:0] busy_f, lock_f, man_f;

  xrs_filt #(.STABLE_CYC(STABLE_CYC), .INIT(1'b0)) u_f_txlock (
    .clk(clk), .rst(rst_i), .d(tx_pll_lock), .q(tx_lock_f));
  xrs_filt #(.STABLE_CYC(STABLE_CYC), .INIT(1'b0)) u_f_txman (
    .clk(clk), .rst(rst_i), .d(tx_manual), .q(tx_man_f));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_rxf
      xrs_filt #(.STABLE_CYC(STABLE_CYC), .INIT(1'b1)) u_f_busy (
        .clk(clk), .rst(rst_i), .d(rx_cal_busy[c]), .q(busy_f[c]));
      xrs_filt #(.STABLE_CYC(STABLE_CYC), .INIT(1'b0)) u_f_lock (
        .clk(clk), .rst(rst_i), .d(rx_cdr_lock[c]), .q(lock_f[c]));
      xrs_filt #(.STABLE_CYC(STABLE_CYC), .INIT(1'b0)) u_f_man (
        .clk(clk), .rst(rst_i), .d(rx_manual[c]), .q(man_f[c]));
    end
  endgenerate

  logic tx_ana_q, tx_dig_q, tx_rdy_q;

  xrs_seq #(.ANA_HOLD(ANA_HOLD), .REL_DLY(REL_DLY)) u_tx (
    .clk(clk), .rst(rst_i), .gate_i(1'b0), .lock_i(tx_lock_f),
    .man_i(tx_man_f), .ana_o(tx_ana_q), .dig_o(tx_dig_q), .rdy_o(tx_rdy_q));

  logic [NUM_CH-1:0] rx_ana_q, rx_dig_q, rx_rdy_q;

  generate
    if (SEPARATE_RX) begin : g_sep
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        xrs_seq #(.ANA_HOLD(ANA_HOLD), .REL_DLY(REL_DLY)) u_rx (
          .clk(clk), .rst(rst_i), .gate_i(busy_f[c]), .lock_i(lock_f[c]),
          .man_i(man_f[c]), .ana_o(rx_ana_q[c]), .dig_o(rx_dig_q[c]),
          .rdy_o(rx_rdy_q[c]));
      end
    end else begin : g_shr
      logic s_ana, s_dig, s_rdy;
      xrs_seq #(.ANA_HOLD(ANA_HOLD), .REL_DLY(REL_DLY)) u_rx (
        .clk(clk), .rst(rst_i), .gate_i(|busy_f), .lock_i(&lock_f),
        .man_i(man_f[0]), .ana_o(s_ana), .dig_o(s_dig), .rdy_o(s_rdy));
      assign rx_ana_q = {NUM_CH{s_ana}};
      assign rx_dig_q = {NUM_CH{s_dig}};
      assign rx_rdy_q = {NUM_CH{s_rdy}};
    end
  endgenerate

  assign tx_ana_rst = rst | tx_ana_q;
  assign tx_dig_rst = rst | tx_dig_q;
  assign tx_ready   = ~rst & tx_rdy_q;
  assign rx_ana_rst = {NUM_CH{rst}} | rx_ana_q;
  assign rx_dig_rst = {NUM_CH{rst}} | rx_dig_q;
  assign rx_ready   = {NUM_CH{~rst}} & rx_rdy_q;
endmodule

// File: tb/xcvr_rst_seq_test.sv
module xcvr_rst_seq_test;
  localparam int S  = 3;
  localparam int AH = 6;
  localparam int DL = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_lock = 1'b0, tx_man = 1'b0;
  logic [1:0] busy = 2'b01, cdr = 2'b11, rman = 2'b00;
  logic [1:0] s_busy = 2'b00, s_cdr = 2'b01, s_man = 2'b00;

  logic tx_ana, tx_dig, tx_rdy;
  logic [1:0] rx_ana, rx_dig, rx_rdy;
  logic s_txa, s_txd, s_txr;
  logic [1:0] s_ana, s_dig, s_rdy;

  int total = 0, bad = 0, cyc = 0;
  int tx_ana_fall = 0, tx_dig_fall = 0, tx_rdy_rise = 0;
  int r0_ana_fall = 0, r0_dig_fall = 0, r0_rdy_rise = 0;
  logic p_tx_ana = 1, p_tx_dig = 1, p_tx_rdy = 0;
  logic p_r0_ana = 1, p_r0_dig = 1, p_r0_rdy = 0;

  always #10 clk = ~clk;

  xcvr_rst_seq #(.NUM_CH(2), .SEPARATE_RX(1'b1), .STABLE_CYC(S),
    .ANA_HOLD(AH), .REL_DLY(DL), .SYNC_RESET(1'b1)) uut (
    .clk(clk), .rst(rst), .tx_pll_lock(tx_lock), .tx_manual(tx_man),
    .rx_cal_busy(busy), .rx_cdr_lock(cdr), .rx_manual(rman),
    .tx_ana_rst(tx_ana), .tx_dig_rst(tx_dig), .tx_ready(tx_rdy),
    .rx_ana_rst(rx_ana), .rx_dig_rst(rx_dig), .rx_ready(rx_rdy));

  xcvr_rst_seq #(.NUM_CH(2), .SEPARATE_RX(1'b0), .STABLE_CYC(S),
    .ANA_HOLD(AH), .REL_DLY(DL), .SYNC_RESET(1'b1)) uut_shared (
    .clk(clk), .rst(rst), .tx_pll_lock(tx_lock), .tx_manual(tx_man),
    .rx_cal_busy(s_busy), .rx_cdr_lock(s_cdr), .rx_manual(s_man),
    .tx_ana_rst(s_txa), .tx_dig_rst(s_txd), .tx_ready(s_txr),
    .rx_ana_rst(s_ana), .rx_dig_rst(s_dig), .rx_ready(s_rdy));

  always @(negedge clk) begin
    cyc++;
    if (p_tx_ana && !tx_ana) tx_ana_fall = cyc;
    if (p_tx_dig && !tx_dig) tx_dig_fall = cyc;
    if (!p_tx_rdy && tx_rdy) tx_rdy_rise = cyc;
    if (p_r0_ana && !rx_ana[0]) r0_ana_fall = cyc;
    if (p_r0_dig && !rx_dig[0]) r0_dig_fall = cyc;
    if (!p_r0_rdy && rx_rdy[0]) r0_rdy_rise = cyc;
    p_tx_ana = tx_ana; p_tx_dig = tx_dig; p_tx_rdy = tx_rdy;
    p_r0_ana = rx_ana[0]; p_r0_dig = rx_dig[0]; p_r0_rdy = rx_rdy[0];
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 tx outputs in reset", {tx_ana, tx_dig, tx_rdy}, 3'b110);
    chk("R1 rx outputs in reset", {rx_ana, rx_dig, rx_rdy}, 6'b111100);
  endtask

  task automatic t_bringup();
    int c0;
    rst = 1'b0;
    tick(40);
    chk("R3 tx analog released before lock", tx_ana, 0);
    chk("R6 tx digital waits for lock", tx_dig, 1);
    tx_lock = 1'b1;
    c0 = cyc;
    tick(40);
    chk("R3 tx analog fell before digital", int'(tx_ana_fall < tx_dig_fall), 1);
    chk_rng("R4 tx digital release delay", tx_dig_fall - c0, S + DL, S + DL + 4);
    chk("R4 tx ready one cycle after digital", tx_rdy_rise - tx_dig_fall, 1);
    chk("R4 tx ready high", tx_rdy, 1);
  endtask

  task automatic t_cal_gate();
    chk("R7 busy ch0 analog held", rx_ana[0], 1);
    chk("R7 busy ch0 digital held", rx_dig[0], 1);
    chk("R7 busy ch0 not ready", rx_rdy[0], 0);
    chk("R10 ch1 ready independently", rx_rdy[1], 1);
    busy = 2'b00;
    tick(40);
    chk("R7 ch0 ready after busy clears", rx_rdy[0], 1);
    chk("R3 rx0 analog fell before digital", int'(r0_ana_fall < r0_dig_fall), 1);
    chk("R4 rx0 ready one cycle after digital", r0_rdy_rise - r0_dig_fall, 1);
  endtask

  task automatic t_glitch();
    int drops = 0;
    tx_lock = 1'b0;
    tick(1);
    tx_lock = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (!tx_rdy) drops++;
    end
    chk("R2 short lock glitch ignored", drops, 0);
  endtask

  task automatic t_tx_auto();
    tx_lock = 1'b0;
    tick(S + 6);
    chk("R5 tx digital reasserted on loss", tx_dig, 1);
    chk("R5 tx ready cleared on loss", tx_rdy, 0);
    chk("R5 tx analog stays released", tx_ana, 0);
    tx_lock = 1'b1;
    tick(40);
    chk("R5 tx ready after lock returns", tx_rdy, 1);
  endtask

  task automatic t_rx_modes();
    rman = 2'b10;
    tick(10);
    cdr = 2'b00;
    tick(20);
    chk("R8 rx0 auto digital reasserted", rx_dig[0], 1);
    chk("R8 rx0 auto ready cleared", rx_rdy[0], 0);
    chk("R9 rx1 manual ready kept", rx_rdy[1], 1);
    chk("R9 rx1 manual digital kept low", rx_dig[1], 0);
    cdr = 2'b11;
    tick(40);
    chk("R8 rx0 ready after lock returns", rx_rdy[0], 1);
  endtask

  task automatic t_tx_manual();
    tx_man = 1'b1;
    tick(10);
    tx_lock = 1'b0;
    tick(30);
    chk("R6 manual tx ignores lock loss", {tx_dig, tx_rdy}, 2'b01);
    rst = 1'b1;
    #1;
    chk("R1 reset asserts outputs at once", {tx_ana, tx_dig, tx_rdy, rx_rdy}, 5'b11000);
    tick(5);
    chk("R1 reset holds outputs", {tx_ana, tx_dig, rx_ana, rx_dig}, 6'b111111);
    rst = 1'b0;
    tick(50);
    chk("R6 manual first release waits lock", {tx_dig, tx_rdy}, 2'b10);
    tx_lock = 1'b1;
    tick(40);
    chk("R6 manual first release after lock", tx_rdy, 1);
  endtask

  task automatic t_shared();
    s_cdr = 2'b01;
    tick(40);
    chk("R11 shared partial lock keeps digital", s_dig, 2'b11);
    chk("R11 shared partial lock not ready", s_rdy, 2'b00);
    s_cdr = 2'b11;
    tick(40);
    chk("R11 shared full lock ready all", s_rdy, 2'b11);
    chk("R11 shared outputs identical", {s_ana, s_dig}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_bringup();
    t_cal_gate();
    t_glitch();
    t_tx_auto();
    t_rx_modes();
    t_tx_manual();
    t_shared();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule